// File: doc/BRIEF.md
# Discrete Latch Bank Mapper

This block is the bank register of a simple cartridge memory map built from discrete logic. Any CPU write that lands in the upper 32 KiB of the 64 KiB CPU space loads one byte into a single register. The fields of that byte then supply the upper address bits of the program ROM and of the character (pattern) memory. In some layouts they also supply a single-screen nametable select. Writes in the lower half of the CPU space leave the register untouched.

The field layout is fixed when the block is elaborated, through the `LAYOUT` parameter. With `BUS_CONFLICT` set, the register stores the CPU data ANDed bit by bit with the ROM byte that the cartridge drives at the written address. This models the two drivers fighting on an open-drain-like bus. With `BUS_CONFLICT` clear, the register stores the raw CPU data.

`PRG_AW` and `CHR_AW` give the byte address widths of the program and character memories. Each bank field keeps only as many low bits as the memory has banks. The ROM arrays, the CPU and the picture unit sit outside the block. The block only forms the addresses and the mirroring select.

Top module: `dlatch_mapper`

## Requirements
- R1: While reset is active, and after it until the first accepted write, every bank field is zero and `mirror_screen` is 0. In layout `LAY_P16C8`/`LAY_P16C8_SCR`, CPU address 0xC000 still maps to the last 16 KiB bank.
- R2: With `BUS_CONFLICT`=1, an accepted write stores `cpu_wdata & rom_rdata`.
- R3: With `BUS_CONFLICT`=0, an accepted write stores `cpu_wdata` unchanged, whatever `rom_rdata` holds.
- R4: A write with `cpu_addr[15]`=0 has no effect on any output.
- R5: In `LAY_P32C8`, bits 5:4 select the 32 KiB program bank, so `prg_addr` = bank*0x8000 + `cpu_addr[14:0]`. Bits 1:0 select the 8 KiB character bank, so `chr_addr` = bank*0x2000 + `ppu_addr`.
- R6: In `LAY_SCR32`, bit 4 drives `mirror_screen` (1 = screen 1) and bits 3:0 select the 32 KiB program bank. `chr_addr` equals `ppu_addr`.
- R7: In the 16 KiB layouts, bits 7:4 select the bank seen at CPU 0x8000–0xBFFF, and CPU 0xC000–0xFFFF always maps to the last 16 KiB bank. Bits 3:0 select the 8 KiB character bank.
- R8: In `LAY_P16C8_SCR`, bit 7 also drives `mirror_screen`: set gives screen 1, clear gives screen 0.
- R9: In `LAY_C4HI`, bits 1:0 select the 4 KiB character bank seen at pattern addresses 0x1000–0x1FFF. Pattern addresses 0x0000–0x0FFF always map to 4 KiB page 0, and the program bank is fixed at 0.
- R10: Each bank field is cut to its low log2(bank count) bits. For example, with `PRG_AW`=17 a 32 KiB bank field keeps 2 bits and a 16 KiB bank field keeps 3 bits.
- R11: With no accepted write, the register holds its value. Layouts without a screen field keep `mirror_screen` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| rom_rdata | input | 8 | Program ROM byte at `cpu_addr` |
| ppu_addr | input | 13 | Pattern-space address, 0x0000–0x1FFF |
| prg_addr | output | PRG_AW | Program ROM byte address |
| chr_addr | output | CHR_AW | Character memory byte address |
| mirror_screen | output | 1 | Single-screen nametable select |

## Verification
The hardest case to reach is the bank field cut-down. It only shows when the stored byte carries bank bits above the ones the memory can use. The stimulus therefore writes all-ones and 0x15 patterns to sizes whose fields are narrower than the layout field. It then reads the resulting addresses at both the lower and the fixed upper program window.

Bus conflicts are driven with CPU data and ROM bytes that have disjoint ones. Several instances share each write, so the same cycle shows a conflict-free instance storing the raw byte while a conflicted one stores zero.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  typedef enum logic [2:0] {
    LAY_P32C8     = 3'd0,
    LAY_SCR32     = 3'd1,
    LAY_P16C8     = 3'd2,
    LAY_P16C8_SCR = 3'd3,
    LAY_C4HI      = 3'd4
  } layout_e;

  localparam int unsigned PRG32_SHIFT = 15;
  localparam int unsigned PRG16_SHIFT = 14;
  localparam int unsigned CHR8_SHIFT  = 13;
  localparam int unsigned CHR4_SHIFT  = 12;

  // Low-bit mask for a field that may address 2**bits banks (field is 4 wide).
  function automatic logic [3:0] field_mask(input int unsigned bits);
    if (bits >= 4) return 4'hF;
    return 4'((32'd1 << bits) - 32'd1);
  endfunction

  function automatic bit is_prg16(input layout_e lay);
    return (lay == LAY_P16C8) || (lay == LAY_P16C8_SCR);
  endfunction

endpackage

// File: rtl/dlm_rst_sync.sv
module dlm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/dlm_bank_latch.sv
module dlm_bank_latch #(
  parameter bit          BUS_CONFLICT = 1'b1,
  parameter int unsigned DW           = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cpu_hi,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] rom_rdata,
  output logic [DW-1:0] latch_q
);

  logic          wr_hit;
  logic [DW-1:0] latch_d;

  always_comb begin
    wr_hit = cpu_we && cpu_hi;
    if (BUS_CONFLICT) begin
      latch_d = cpu_wdata & rom_rdata;
    end else begin
      latch_d = cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      latch_q <= '0;
    end else if (wr_hit) begin
      latch_q <= latch_d;
    end
  end

  // R1: cleared while reset holds
  p_reset_clear_r1: assert property (@(posedge clk) !srst_n |-> latch_q == '0)
    else $error("R1 latch not clear in reset");

  // R4: writes to the lower half leave the register alone
  p_low_write_ignored_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (cpu_we && !cpu_hi) |=> $stable(latch_q))
    else $error("R4 low write changed latch");

  // R11: no write, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !cpu_we |=> $stable(latch_q))
    else $error("R11 latch moved without write");

  generate
    if (BUS_CONFLICT) begin : g_conf_chk
      // R2: no stored one where the ROM drove a zero
      p_conflict_and_r2: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_we && cpu_hi) |=> ((latch_q & ~$past(rom_rdata)) == '0))
        else $error("R2 conflict mask violated");
    end else begin : g_raw_chk
      // R3: raw data stored
      p_raw_store_r3: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_we && cpu_hi) |=> (latch_q == $past(cpu_wdata)))
        else $error("R3 raw store mismatch");
    end
  endgenerate

endmodule

// File: rtl/dlm_field_decode.sv
module dlm_field_decode
  import dlm_pkg::*;
#(
  parameter layout_e     LAYOUT = LAY_P32C8,
  parameter int unsigned PRG_AW = 17,
  parameter int unsigned CHR_AW = 15
) (
  input  logic [7:0] latch_q,
  output logic [3:0] prg_bank,
  output logic [3:0] chr_bank,
  output logic       screen
);

  localparam bit          PRG16    = is_prg16(LAYOUT);
  localparam bit          CHR4     = (LAYOUT == LAY_C4HI);
  localparam int unsigned PRG_BITS = PRG16 ? (PRG_AW - PRG16_SHIFT) : (PRG_AW - PRG32_SHIFT);
  localparam int unsigned CHR_BITS = CHR4 ? (CHR_AW - CHR4_SHIFT) : (CHR_AW - CHR8_SHIFT);
  localparam logic [3:0]  PRG_MASK = field_mask(PRG_BITS);
  localparam logic [3:0]  CHR_MASK = field_mask(CHR_BITS);

  logic [3:0] prg_raw;
  logic [3:0] chr_raw;

  always_comb begin
    prg_raw = 4'h0;
    chr_raw = 4'h0;
    screen  = 1'b0;
    unique case (LAYOUT)
      LAY_P32C8: begin
        prg_raw = {2'b00, latch_q[5:4]};
        chr_raw = {2'b00, latch_q[1:0]};
      end
      LAY_SCR32: begin
        prg_raw = latch_q[3:0];
        screen  = latch_q[4];
      end
      LAY_P16C8: begin
        prg_raw = latch_q[7:4];
        chr_raw = latch_q[3:0];
      end
      LAY_P16C8_SCR: begin
        prg_raw = latch_q[7:4];
        chr_raw = latch_q[3:0];
        screen  = latch_q[7];
      end
      LAY_C4HI: begin
        chr_raw = {2'b00, latch_q[1:0]};
      end
      default: begin
        prg_raw = 4'h0;
      end
    endcase
    prg_bank = prg_raw & PRG_MASK;
    chr_bank = chr_raw & CHR_MASK;
  end

endmodule

// File: rtl/dlm_addr_map.sv
module dlm_addr_map
  import dlm_pkg::*;
#(
  parameter layout_e     LAYOUT = LAY_P32C8,
  parameter int unsigned PRG_AW = 17,
  parameter int unsigned CHR_AW = 15
) (
  input  logic [14:0]       cpu_off,
  input  logic [12:0]       ppu_addr,
  input  logic [3:0]        prg_bank,
  input  logic [3:0]        chr_bank,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr
);

  localparam bit PRG16 = is_prg16(LAYOUT);
  localparam bit CHR4  = (LAYOUT == LAY_C4HI);

  generate
    if (PRG16) begin : g_prg16
      localparam logic [3:0] LAST_BANK = field_mask(PRG_AW - PRG16_SHIFT);
      logic [3:0] bank_eff;
      always_comb begin
        bank_eff = cpu_off[14] ? LAST_BANK : prg_bank;
        prg_addr = (PRG_AW'(bank_eff) << PRG16_SHIFT) | PRG_AW'(cpu_off[13:0]);
      end
    end else begin : g_prg32
      always_comb begin
        prg_addr = (PRG_AW'(prg_bank) << PRG32_SHIFT) | PRG_AW'(cpu_off);
      end
    end

    if (CHR4) begin : g_chr4
      logic [3:0] page_eff;
      always_comb begin
        page_eff = ppu_addr[12] ? chr_bank : 4'h0;
        chr_addr = (CHR_AW'(page_eff) << CHR4_SHIFT) | CHR_AW'(ppu_addr[11:0]);
      end
    end else begin : g_chr8
      always_comb begin
        chr_addr = (CHR_AW'(chr_bank) << CHR8_SHIFT) | CHR_AW'(ppu_addr);
      end
    end
  endgenerate

endmodule

// File: rtl/dlatch_mapper.sv
module dlatch_mapper
  import dlm_pkg::*;
#(
  parameter layout_e     LAYOUT       = LAY_P32C8,
  parameter bit          BUS_CONFLICT = 1'b1,
  parameter int unsigned PRG_AW       = 17,
  parameter int unsigned CHR_AW       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        rom_rdata,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              mirror_screen
);

  logic       srst_n;
  logic [7:0] latch_q;
  logic [3:0] prg_bank;
  logic [3:0] chr_bank;

  dlm_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dlm_bank_latch #(
    .BUS_CONFLICT (BUS_CONFLICT),
    .DW           (8)
  ) i_bank_latch (
    .clk       (clk),
    .srst_n    (srst_n),
    .cpu_hi    (cpu_addr[15]),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .rom_rdata (rom_rdata),
    .latch_q   (latch_q)
  );

  dlm_field_decode #(
    .LAYOUT (LAYOUT),
    .PRG_AW (PRG_AW),
    .CHR_AW (CHR_AW)
  ) i_field_decode (
    .latch_q  (latch_q),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .screen   (mirror_screen)
  );

  dlm_addr_map #(
    .LAYOUT (LAYOUT),
    .PRG_AW (PRG_AW),
    .CHR_AW (CHR_AW)
  ) i_addr_map (
    .cpu_off  (cpu_addr[14:0]),
    .ppu_addr (ppu_addr),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .prg_addr (prg_addr),
    .chr_addr (chr_addr)
  );

  generate
    if (is_prg16(LAYOUT)) begin : g_chk_prg16
      // R7: upper 16 KiB window pinned to last bank
      p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!srst_n)
        cpu_addr[14] |-> (prg_addr[PRG_AW-1:PRG16_SHIFT] == {(PRG_AW-PRG16_SHIFT){1'b1}}))
        else $error("R7 upper window not last bank");
    end
    if (LAYOUT == LAY_C4HI) begin : g_chk_c4
      // R9: lower pattern half stays on page 0
      p_chr_low_fixed_r9: assert property (@(posedge clk) disable iff (!srst_n)
        !ppu_addr[12] |-> (chr_addr[CHR_AW-1:CHR4_SHIFT] == '0))
        else $error("R9 lower pattern half moved");
    end
    if (LAYOUT == LAY_P16C8_SCR) begin : g_chk_scr7
      // R8: screen follows stored bit 7
      p_screen_bit7_r8: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_we && cpu_addr[15]) |=>
          (mirror_screen == ($past(cpu_wdata[7]) && ($past(rom_rdata[7]) || !BUS_CONFLICT))))
        else $error("R8 screen select mismatch");
    end
    if (LAYOUT == LAY_SCR32) begin : g_chk_scr4
      // R6: screen follows stored bit 4
      p_screen_bit4_r6: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_we && cpu_addr[15]) |=>
          (mirror_screen == ($past(cpu_wdata[4]) && ($past(rom_rdata[4]) || !BUS_CONFLICT))))
        else $error("R6 screen select mismatch");
    end
  endgenerate

endmodule

// File: tb/test_dlatch_mapper.sv
module test_dlatch_mapper;
  import dlm_pkg::*;

  localparam int unsigned PA = 17;
  localparam int unsigned CA = 15;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic [7:0]  rom_rdata;
  logic [12:0] ppu_addr;

  logic [PA-1:0] prg_m, prg_s, prg_h, prg_c;
  logic [CA-1:0] chr_m, chr_s, chr_h, chr_c;
  logic          scr_m, scr_s, scr_h, scr_c;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  dlatch_mapper #(.LAYOUT(LAY_P32C8), .BUS_CONFLICT(1'b1), .PRG_AW(PA), .CHR_AW(CA)) i_dlatch_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .prg_addr(prg_m), .chr_addr(chr_m), .mirror_screen(scr_m));

  dlatch_mapper #(.LAYOUT(LAY_SCR32), .BUS_CONFLICT(1'b0), .PRG_AW(PA), .CHR_AW(CA)) i_dlatch_mapper_scr (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .prg_addr(prg_s), .chr_addr(chr_s), .mirror_screen(scr_s));

  dlatch_mapper #(.LAYOUT(LAY_P16C8_SCR), .BUS_CONFLICT(1'b1), .PRG_AW(PA), .CHR_AW(CA)) i_dlatch_mapper_p16 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .prg_addr(prg_h), .chr_addr(chr_h), .mirror_screen(scr_h));

  dlatch_mapper #(.LAYOUT(LAY_C4HI), .BUS_CONFLICT(1'b1), .PRG_AW(PA), .CHR_AW(CA)) i_dlatch_mapper_c4 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .prg_addr(prg_c), .chr_addr(chr_c), .mirror_screen(scr_c));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    rom_rdata = r;
    cpu_we    = 1'b1;
    @(negedge clk);
    cpu_we    = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [12:0] p);
    @(negedge clk);
    cpu_addr = a;
    ppu_addr = p;
    #2;
  endtask

  task automatic t_reset;
    probe(16'h8000, 13'h0000);
    check("R1 prg", 32'(prg_m), 32'h0);
    check("R1 chr", 32'(chr_m), 32'h0);
    check("R1 screen", 32'(scr_m), 32'h0);
    check("R1 scr-layout screen", 32'(scr_s), 32'h0);
    check("R1 p16 lower", 32'(prg_h), 32'h0);
    probe(16'hC000, 13'h0000);
    check("R1 p16 upper last", 32'(prg_h), 32'h1C000);
  endtask

  task automatic t_p32;
    bus_write(16'h8000, 8'hFF, 8'h33);   // stored 0x33
    probe(16'h8123, 13'h0456);
    check("R5 R2 prg", 32'(prg_m), 32'h18123);
    check("R5 R2 chr", 32'(chr_m), 32'h6456);
    check("R11 no screen field", 32'(scr_m), 32'h0);
    bus_write(16'hFFFF, 8'h2E, 8'hFF);   // stored 0x2E
    probe(16'hCABC, 13'h1FFF);
    check("R5 prg pattern2", 32'(prg_m), 32'h14ABC);
    check("R5 chr pattern2", 32'(chr_m), 32'h5FFF);
  endtask

  task automatic t_conflict;
    bus_write(16'h9000, 8'hF0, 8'h0F);   // conflicted: 0x00, raw: 0xF0
    probe(16'h8000, 13'h0000);
    check("R2 prg zeroed", 32'(prg_m), 32'h0);
    check("R2 chr zeroed", 32'(chr_m), 32'h0);
    check("R3 raw screen", 32'(scr_s), 32'h1);
  endtask

  task automatic t_ignore;
    bus_write(16'h7FFF, 8'hFF, 8'hFF);
    probe(16'h8000, 13'h0000);
    check("R4 prg kept", 32'(prg_m), 32'h0);
    check("R4 screen kept", 32'(scr_s), 32'h1);
    @(negedge clk);
    cpu_wdata = 8'hFF;
    rom_rdata = 8'hFF;
    repeat (3) @(negedge clk);
    probe(16'h8000, 13'h0000);
    check("R11 hold prg", 32'(prg_m), 32'h0);
  endtask

  task automatic t_scr;
    bus_write(16'h8000, 8'h15, 8'h00);   // raw 0x15: screen 1, bank 5 -> 1
    probe(16'h8000, 13'h1234);
    check("R6 screen set", 32'(scr_s), 32'h1);
    check("R6 R10 R3 prg", 32'(prg_s), 32'h08000);
    check("R6 chr pass", 32'(chr_s), 32'h1234);
    bus_write(16'hA000, 8'h02, 8'h00);
    probe(16'h8000, 13'h0000);
    check("R6 screen clear", 32'(scr_s), 32'h0);
    check("R6 prg bank2", 32'(prg_s), 32'h10000);
  endtask

  task automatic t_p16;
    bus_write(16'h8000, 8'hFF, 8'hFF);   // bank 15->7, chr 15->3
    probe(16'h8001, 13'h0010);
    check("R7 R10 lower", 32'(prg_h), 32'h1C001);
    check("R7 R10 chr", 32'(chr_h), 32'h6010);
    check("R8 screen 1", 32'(scr_h), 32'h1);
    probe(16'hC002, 13'h0010);
    check("R7 upper", 32'(prg_h), 32'h1C002);
    bus_write(16'h8000, 8'h52, 8'hFF);
    probe(16'h8000, 13'h0000);
    check("R7 lower bank5", 32'(prg_h), 32'h14000);
    check("R7 chr bank2", 32'(chr_h), 32'h4000);
    check("R8 screen 0", 32'(scr_h), 32'h0);
    probe(16'hC000, 13'h0000);
    check("R7 upper still last", 32'(prg_h), 32'h1C000);
  endtask

  task automatic t_c4;
    bus_write(16'hB000, 8'h07, 8'hFE);   // stored 0x06 -> page 2
    probe(16'hFFFF, 13'h1ABC);
    check("R9 upper page", 32'(chr_c), 32'h2ABC);
    check("R9 prg fixed", 32'(prg_c), 32'h07FFF);
    check("R11 c4 screen", 32'(scr_c), 32'h0);
    probe(16'hFFFF, 13'h0ABC);
    check("R9 lower fixed", 32'(chr_c), 32'h0ABC);
  endtask

  initial begin
    rst_n     = 1'b0;
    cpu_addr  = 16'h0000;
    cpu_we    = 1'b0;
    cpu_wdata = 8'h00;
    rom_rdata = 8'h00;
    ppu_addr  = 13'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_p32();
    t_conflict();
    t_ignore();
    t_scr();
    t_p16();
    t_c4();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule